// File: doc/BRIEF.md
# ADC Conversion Trigger and Channel Scan Sequencer

This block decides when an analog-to-digital converter begins a conversion and which input it samples. A start can come from three places. Software can write a strobe address. A pacer built from two cascaded reloadable counters can tick. An external trigger pin can rise. A small byte-wide register port selects the source and sets the channel, the gain code and the pacer divisors.

In autoscan mode the block walks channels upward from zero to a programmed top channel and then wraps to zero. Otherwise it samples one fixed channel on every start. The converter receives a one-cycle start pulse together with a channel index and a 3-bit gain code. A busy flag covers each conversion until the converter reports done, and starts that arrive during that window are dropped.

The pacer counts strobes on `ref_tick_i`, which stand for periods of the slow reference clock. A pacer tick therefore occurs every `div1 * div2` reference strobes. The shortest period the block must support is 20 reference periods.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, start_o and busy_o are 0, chan_o is 0, range_o is 0, autoscan is off, the source is software and both divisors are 0.
- R2: Register map (addr_i): 0 control, 1 channel, 2 range, 3 soft strobe, 4/5 first divisor low/high byte, 6/7 second divisor low/high byte. In software mode, any write to address 3 gives exactly one start_o pulse, in the cycle after the write edge.
- R3: Control byte bit 0 enables autoscan, bit 1 selects the pacer and bit 2 selects the external trigger. When bit 1 or bit 2 is set, writes to address 3 produce no start.
- R4: busy_o rises with start_o and stays high until conv_done_i is sampled high. While busy_o is high, every trigger is ignored.
- R5: With autoscan off, chan_o equals the low channel bits of register 1 on every start.
- R6: With autoscan on, successive starts use channels 0, 1, …, the value of register 1, then wrap to 0. chan_o holds the sampled channel during the start_o pulse.
- R7: A write to the channel register, or a control write with bit 0 clear, returns the scan position to channel 0.
- R8: range_o equals bits 2:0 of the last range write, for every channel of a scan. Upper bits have no effect.
- R9: In pacer mode, a start occurs every div1*div2 ref_tick_i strobes. Counting begins with the first strobe after the control write that enters pacer mode. A period of 20 strobes (for example 4*5) is honoured.
- R10: A divisor value of 0 or 1 counts as 2.
- R11: In external mode, ext_trig_i passes through a two-flop synchroniser. Only a rising edge starts a conversion, with start_o high in the third cycle after the input rises. A held-high level gives one start.
- R12: With both bit 1 and bit 2 set, the external trigger is the source and pacer ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| ref_tick_i | input | 1 | One strobe per reference clock period |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| conv_done_i | input | 1 | Converter finished the current conversion |
| start_o | output | 1 | One-cycle start-conversion pulse |
| busy_o | output | 1 | Conversion in progress |
| chan_o | output | 4 | Channel index for the converter |
| range_o | output | 3 | Gain code for the converter |

## Verification
The hardest situation to reach is a trigger arriving while a conversion is still pending. The bench models the converter's done signal in two ways. It can answer every start automatically one cycle later, or it can withhold the answer under test control. Holding done back keeps busy_o high so that a second soft strobe falls into the window where it must be dropped. Scan wrap-around and the position reset are reached by a vector table of register writes, each followed by a strobe. Each vector rewrites the top channel or the autoscan bit mid-scan and checks the next channel issued. The pacer and the external source are exercised by counting cycles between start pulses, including a divisor of 1 that must act as 2.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int ADDR_W  = 3;
  localparam int RANGE_W = 3;

  localparam int CTRL_SCAN_BIT  = 0;
  localparam int CTRL_PACER_BIT = 1;
  localparam int CTRL_EXT_BIT   = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 3'd0,
    A_CHAN    = 3'd1,
    A_RANGE   = 3'd2,
    A_SOFT    = 3'd3,
    A_DIV_BASE = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    SRC_SOFT  = 2'd0,
    SRC_PACER = 2'd1,
    SRC_EXT   = 2'd2
  } trig_src_e;
endpackage

// File: rtl/adc_seq_regs.sv
`timescale 1ns/1ps
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int CH_W       = 4,
  parameter int DIV_W      = 16,
  parameter int NUM_STAGES = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [7:0]                        wdata_i,
  output logic                              scan_en_o,
  output trig_src_e                         src_o,
  output logic [CH_W-1:0]                   chan_o,
  output logic [RANGE_W-1:0]                range_o,
  output logic                              soft_o,
  output logic                              pos_clr_o,
  output logic [NUM_STAGES-1:0][DIV_W-1:0]  div_o
);
  logic scan_q, pacer_q, ext_q;
  logic [CH_W-1:0]    chan_q;
  logic [RANGE_W-1:0] range_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scan_q  <= 1'b0;
      pacer_q <= 1'b0;
      ext_q   <= 1'b0;
      chan_q  <= '0;
      range_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL) begin
        scan_q  <= wdata_i[CTRL_SCAN_BIT];
        pacer_q <= wdata_i[CTRL_PACER_BIT];
        ext_q   <= wdata_i[CTRL_EXT_BIT];
      end
      if (addr_i == A_CHAN)  chan_q  <= wdata_i[CH_W-1:0];
      if (addr_i == A_RANGE) range_q <= wdata_i[RANGE_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_div
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(int'(A_DIV_BASE) + 2*g);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(int'(A_DIV_BASE) + 2*g + 1);
    logic [DIV_W-1:0] div_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) div_q <= '0;
      else if (wr_en_i && addr_i == LO_ADDR) div_q[7:0] <= wdata_i;
      else if (wr_en_i && addr_i == HI_ADDR) div_q[DIV_W-1:8] <= wdata_i[DIV_W-9:0];
    end
    assign div_o[g] = div_q;
  end

  // external select outranks the pacer
  always_comb begin
    if (ext_q)        src_o = SRC_EXT;
    else if (pacer_q) src_o = SRC_PACER;
    else              src_o = SRC_SOFT;
  end

  assign scan_en_o = scan_q;
  assign chan_o    = chan_q;
  assign range_o   = range_q;
  assign soft_o    = wr_en_i && (addr_i == A_SOFT);
  assign pos_clr_o = wr_en_i && ((addr_i == A_CHAN) ||
                                 ((addr_i == A_CTRL) && !wdata_i[CTRL_SCAN_BIT]));
endmodule

// File: rtl/adc_seq_div_stage.sv
`timescale 1ns/1ps
module adc_seq_div_stage #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             wrap_o
);
  logic [DIV_W-1:0] eff_div, cnt_q;

  // divide-by-1 or 0 is not supported; run as divide-by-2
  assign eff_div = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
  assign wrap_o  = en_i && step_i && (cnt_q == DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= DIV_W'(2);
    else if (!en_i)     cnt_q <= eff_div;
    else if (step_i)    cnt_q <= (cnt_q == DIV_W'(1)) ? eff_div : cnt_q - 1'b1;
  end

  AST_CNT_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q != '0); // R10
endmodule

// File: rtl/adc_seq_pacer.sv
`timescale 1ns/1ps
module adc_seq_pacer #(
  parameter int DIV_W      = 16,
  parameter int NUM_STAGES = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             en_i,
  input  logic                             ref_tick_i,
  input  logic [NUM_STAGES-1:0][DIV_W-1:0] div_i,
  output logic                             tick_o
);
  logic [NUM_STAGES:0] carry;
  assign carry[0] = ref_tick_i;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    adc_seq_div_stage #(.DIV_W(DIV_W)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .step_i (carry[g]),
      .div_i  (div_i[g]),
      .wrap_o (carry[g+1])
    );
  end

  assign tick_o = carry[NUM_STAGES];
endmodule

// File: rtl/adc_seq_ext_sync.sv
`timescale 1ns/1ps
module adc_seq_ext_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], ext_i};
  end

  assign rise_o = sh_q[1] && !sh_q[2];

  AST_EXT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R11
endmodule

// File: rtl/adc_seq_scan.sv
`timescale 1ns/1ps
module adc_seq_scan #(
  parameter int CH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scan_en_i,
  input  logic [CH_W-1:0] last_i,
  input  logic            clr_i,
  input  logic            adv_i,
  output logic [CH_W-1:0] pos_o
);
  logic [CH_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pos_q <= '0;
    else if (clr_i)              pos_q <= '0;
    else if (adv_i && scan_en_i) pos_q <= (pos_q == last_i) ? '0 : pos_q + 1'b1;
  end

  assign pos_o = pos_q;

  AST_SCAN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |-> pos_q <= last_i); // R6
  AST_SCAN_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && scan_en_i && !clr_i && pos_q == last_i) |=> pos_q == '0); // R6
endmodule

// File: rtl/adc_trig_seq.sv
`timescale 1ns/1ps
module adc_trig_seq
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int DIV_W      = 16,
  parameter int NUM_STAGES = 2,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               ref_tick_i,
  input  logic               ext_trig_i,
  input  logic               conv_done_i,
  output logic               start_o,
  output logic               busy_o,
  output logic [CH_W-1:0]    chan_o,
  output logic [RANGE_W-1:0] range_o
);
  logic                             scan_en, soft_wr, pos_clr, pacer_tick, ext_rise;
  trig_src_e                        src;
  logic [CH_W-1:0]                  chan_reg, pos;
  logic [NUM_STAGES-1:0][DIV_W-1:0] div;
  logic                             req, fire, start_q, busy_q;

  adc_seq_regs #(.CH_W(CH_W), .DIV_W(DIV_W), .NUM_STAGES(NUM_STAGES)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .scan_en_o (scan_en),
    .src_o     (src),
    .chan_o    (chan_reg),
    .range_o   (range_o),
    .soft_o    (soft_wr),
    .pos_clr_o (pos_clr),
    .div_o     (div)
  );

  adc_seq_pacer #(.DIV_W(DIV_W), .NUM_STAGES(NUM_STAGES)) u_pacer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (src == SRC_PACER),
    .ref_tick_i (ref_tick_i),
    .div_i      (div),
    .tick_o     (pacer_tick)
  );

  adc_seq_ext_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_trig_i),
    .rise_o (ext_rise)
  );

  adc_seq_scan #(.CH_W(CH_W)) u_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scan_en_i (scan_en),
    .last_i    (chan_reg),
    .clr_i     (pos_clr),
    .adv_i     (start_q),
    .pos_o     (pos)
  );

  always_comb begin
    unique case (src)
      SRC_PACER: req = pacer_tick;
      SRC_EXT:   req = ext_rise;
      default:   req = soft_wr;
    endcase
  end

  assign fire = req && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      start_q <= fire;
      if (fire)             busy_q <= 1'b1;
      else if (conv_done_i) busy_q <= 1'b0;
    end
  end

  // position advances after the pulse, so chan_o is stable while start_o is high
  assign chan_o  = scan_en ? pos : chan_reg;
  assign start_o = start_q;
  assign busy_o  = busy_q;

  AST_BUSY_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !conv_done_i) |=> !start_q); // R4
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> busy_q); // R4
endmodule

// File: tb/adc_trig_seq_tb.sv
`timescale 1ns/1ps
module adc_trig_seq_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic ref_tick_i = 1'b0;
  logic ext_trig_i = 1'b0;
  logic conv_done_i = 1'b0;
  logic start_o, busy_o;
  logic [3:0] chan_o;
  logic [2:0] range_o;
  logic auto_done = 1'b0;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  adc_trig_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ref_tick_i(ref_tick_i), .ext_trig_i(ext_trig_i),
    .conv_done_i(conv_done_i), .start_o(start_o), .busy_o(busy_o),
    .chan_o(chan_o), .range_o(range_o)
  );

  // converter model: answers each start one cycle later when enabled
  initial forever begin
    @(negedge clk_i);
    if (auto_done) conv_done_i = start_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // counts start pulses over n cycles; first = index of first pulse (0 if none)
  task automatic watch(input int n, output int cnt, output int first);
    cnt = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk_i);
      if (start_o) begin
        if (cnt == 0) first = i;
        cnt++;
      end
    end
  endtask

  // {addr, data, exp chan, exp range, exp start}
  localparam logic [18:0] VEC [0:13] = '{
    {3'd1, 8'h05, 4'd5, 3'd0, 1'b1},
    {3'd2, 8'h03, 4'd5, 3'd3, 1'b1},
    {3'd0, 8'h01, 4'd0, 3'd3, 1'b1},
    {3'd2, 8'h0B, 4'd1, 3'd3, 1'b1},
    {3'd2, 8'h06, 4'd2, 3'd6, 1'b1},
    {3'd1, 8'h02, 4'd0, 3'd6, 1'b1},
    {3'd2, 8'h06, 4'd1, 3'd6, 1'b1},
    {3'd2, 8'h06, 4'd2, 3'd6, 1'b1},
    {3'd2, 8'h06, 4'd0, 3'd6, 1'b1},
    {3'd0, 8'h00, 4'd2, 3'd6, 1'b1},
    {3'd0, 8'h01, 4'd0, 3'd6, 1'b1},
    {3'd0, 8'h02, 4'd2, 3'd6, 1'b0},
    {3'd0, 8'h04, 4'd2, 3'd6, 1'b0},
    {3'd0, 8'h00, 4'd2, 3'd6, 1'b1}
  };

  initial begin
    int cnt, first, t0, t1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(start_o == 1'b0, "R1 start", start_o, 0);
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(chan_o == 4'd0, "R1 chan", chan_o, 0);
    chk(range_o == 3'd0, "R1 range", range_o, 0);

    // vector walk: R2 R3 R5 R6 R7 R8
    auto_done = 1'b1;
    for (int v = 0; v < 14; v++) begin
      logic [18:0] e;
      e = VEC[v];
      wr(e[18:16], e[15:8]);
      @(negedge clk_i);
      wr(3'd3, 8'h00);
      chk({start_o, chan_o, range_o} == {e[0], e[7:4], e[3:1]},
          $sformatf("R2 R3 R5 R6 R7 R8 vector %0d", v),
          {start_o, chan_o, range_o}, {e[0], e[7:4], e[3:1]});
      @(negedge clk_i);
    end

    // R4: strobe while busy is dropped
    auto_done = 1'b0; conv_done_i = 1'b0;
    @(negedge clk_i);
    wr(3'd3, 8'h00);
    chk(start_o && busy_o, "R4 first start", {start_o, busy_o}, 3);
    wr(3'd3, 8'h00);
    chk(!start_o && busy_o, "R4 strobe while busy", {start_o, busy_o}, 1);
    conv_done_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0;
    chk(!busy_o, "R4 busy cleared by done", busy_o, 0);
    wr(3'd3, 8'h00);
    chk(start_o, "R4 start after done", start_o, 1);
    conv_done_i = 1'b1;
    @(negedge clk_i);
    conv_done_i = 1'b0;

    // R9: pacer 4*5 = 20 strobes
    auto_done = 1'b1; ref_tick_i = 1'b1;
    wr(3'd4, 8'd4); wr(3'd5, 8'd0); wr(3'd6, 8'd5); wr(3'd7, 8'd0);
    wr(3'd0, 8'h02);
    t0 = 0; t1 = 0; cnt = 0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk_i);
      if (start_o) begin
        if (cnt == 0) t0 = i;
        if (cnt == 1) t1 = i;
        cnt++;
      end
    end
    chk(t0 == 20, "R9 first pacer start", t0, 20);
    chk(t1 - t0 == 20, "R9 pacer period", t1 - t0, 20);
    chk(cnt == 3, "R9 pacer count", cnt, 3);

    // R10: divisor 1 acts as 2 -> 2*10
    wr(3'd0, 8'h00);
    wr(3'd4, 8'd1); wr(3'd6, 8'd10);
    wr(3'd0, 8'h02);
    watch(25, cnt, first);
    chk(first == 20, "R10 clamped divisor", first, 20);

    // R11: external rising edge, held level
    wr(3'd0, 8'h00);
    ref_tick_i = 1'b0;
    wr(3'd0, 8'h04);
    ext_trig_i = 1'b1;
    watch(12, cnt, first);
    chk(first == 3, "R11 sync latency", first, 3);
    chk(cnt == 1, "R11 one start per edge", cnt, 1);
    ext_trig_i = 1'b0;
    watch(5, cnt, first);
    chk(cnt == 0, "R11 falling edge", cnt, 0);

    // R12: both selects -> external wins, pacer ignored
    ref_tick_i = 1'b1;
    wr(3'd0, 8'h06);
    watch(30, cnt, first);
    chk(cnt == 0, "R12 pacer ignored", cnt, 0);
    ext_trig_i = 1'b1;
    watch(10, cnt, first);
    chk(cnt == 1 && first == 3, "R12 external start", cnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog all actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule